// File: doc/BRIEF.md
# Byte-Mapped GPIO Controller with Interrupt Pins

This block is a general-purpose I/O controller on a byte-wide register bus with single-cycle read and write strobes. The address window starts with a small bank of read-only level-summary bytes. Each I/O pin then has one control byte, which holds an output-enable flag, an output-data bit and a pin-level bit. Software cannot write the level bit directly. When a write sets output-enable, the level bit takes the written data bit. When a write leaves output-enable clear, the level bit keeps its old value.

External logic reports input changes through an event port that carries a pin index and a level. An event changes only the level bit of the addressed pin. Two pins have fixed interrupt wiring. One pin gives an active-low, level-sensitive interrupt. The other gives an active-high interrupt, and a non-maskable-interrupt request pulses that pin for exactly one clock.

A small state machine produces the pulse. In state `NMI_IDLE`, a request forces the pulse pin's level high and takes the transition `IDLE->HIGH`. In state `NMI_HIGH`, the pin's level is forced low, any new request is ignored, and the transition `HIGH->IDLE` is always taken. A sticky diagnostic flag records any input event aimed at a pin whose output driver is enabled.

Top module: `gpio_byte_ctrl`

## Requirements
- R1: After reset, every control byte reads 0x00 except pin 1, which reads 0x02. All level-summary bytes read 0x00, all interrupt outputs are low and the error flag is low.
- R2: Offsets 0 to 7 read the level-summary bank, which holds 0x00. Writes to these offsets change no register and no output.
- R3: The control byte of pin n is at offset 8+n, for n from 0 to 35. Reads at offsets 44 to 63 return 0x00, and writes there change nothing.
- R4: A control write stores every written bit except bit 1. Bit 2 is output-enable and bit 0 is output-data. If written bit 2 is 1, stored bit 1 becomes written bit 0. Otherwise stored bit 1 is unchanged.
- R5: An input event (ext_set with ext_idx and ext_level) replaces only bit 1 of that pin's byte, even when output-enable is set. Events with an index of 36 or more are ignored. If a bus write hits the same pin in the same cycle, the bus write wins.
- R6: irq[1] is high exactly while pin 1's level bit is 0.
- R7: irq[9] equals pin 9's level bit. irq bits 0, 2 to 8 are always 0.
- R8: A request on nmi_req while idle sets pin 9's level to 1 for exactly one cycle, then to 0. This overrides writes and events on that bit. A request that arrives during the pulse is ignored.
- R9: err_flag goes high after an input event targets a pin whose stored output-enable bit is 1. It then stays high until reset.
- R10: Read data is registered. bus_rdata shows the addressed byte from the cycle after bus_rd and holds that value while no read is strobed.
- R11: pin_level[n] always equals bit 1 of pin n's control byte.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| bus_addr | input | 6 | Byte address |
| bus_wr | input | 1 | One-cycle write strobe |
| bus_rd | input | 1 | One-cycle read strobe |
| bus_wdata | input | 8 | Write data |
| bus_rdata | output | 8 | Registered read data |
| ext_set | input | 1 | Input-change event strobe |
| ext_idx | input | 6 | Pin index of the event |
| ext_level | input | 1 | New input level |
| nmi_req | input | 1 | Non-maskable-interrupt request |
| pin_level | output | 36 | Level bit of each pin |
| irq | output | 10 | Interrupt lines indexed by pin |
| err_flag | output | 1 | Sticky event-on-driven-pin flag |

## Verification
The bench writes sixteen byte patterns to every pin and checks the read-back, the level outputs and all interrupt lines against a model held in the bench. A design that let bit 1 be written directly, or that cleared the level when output-enable was off, fails those compares. Writes to the summary bank and above offset 43 are followed by a full-window read, which catches address aliasing. The bench also collides an event with a write on one pin, sends an event with an index out of range and holds the interrupt request for two cycles. A design with a two-cycle pulse, a restarted pulse, or an event that beats the write would show the wrong level.

// File: rtl/gpio_pkg.sv
package gpio_pkg;
    typedef enum logic {
        NMI_IDLE = 1'b0,
        NMI_HIGH = 1'b1
    } nmi_state_t;

    localparam int unsigned DEF_NPIN    = 36;
    localparam int unsigned DEF_NLVL    = 8;
    localparam int unsigned DEF_NIRQ    = 10;
    localparam int unsigned DEF_AW      = 6;
    localparam int unsigned DEF_LOW_PIN = 1;
    localparam int unsigned DEF_NMI_PIN = 9;
endpackage

// File: rtl/gpio_addr_dec.sv
module gpio_addr_dec #(
    parameter int unsigned AW   = 6,
    parameter int unsigned NLVL = 8,
    parameter int unsigned NPIN = 36
) (
    input  logic [AW-1:0] addr,
    output logic          is_lvl,
    output logic          is_ctrl,
    output logic [AW-1:0] pin_idx
);
    localparam int unsigned CTRL_END = NLVL + NPIN;

    always_comb begin
        is_lvl  = (32'(addr) < NLVL);
        is_ctrl = (32'(addr) >= NLVL) && (32'(addr) < CTRL_END);
        pin_idx = addr - AW'(NLVL);
    end
endmodule

// File: rtl/gpio_pin_cell.sv
module gpio_pin_cell #(
    parameter logic [7:0] RST_VAL = 8'h00
) (
    input  logic       clk,
    input  logic       rst_n,
    input  logic       wr_en,
    input  logic [6:0] wr_bits,   // written bits 7..2 and 0
    input  logic       ext_en,
    input  logic       ext_lvl,
    input  logic       force_en,
    input  logic       force_lvl,
    output logic [7:0] ctrl
);
    logic [7:0] nxt;

    always_comb begin
        nxt = ctrl;
        if (wr_en) begin
            nxt[7:2] = wr_bits[6:1];
            nxt[0]   = wr_bits[0];
            if (wr_bits[1]) nxt[1] = wr_bits[0];
        end else if (ext_en) begin
            nxt[1] = ext_lvl;
        end
        if (force_en) nxt[1] = force_lvl;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) ctrl <= RST_VAL;
        else        ctrl <= nxt;
    end
endmodule

// File: rtl/gpio_nmi_seq.sv
module gpio_nmi_seq
    import gpio_pkg::*;
(
    input  logic clk,
    input  logic rst_n,
    input  logic req,
    output logic force_en,
    output logic force_lvl,
    output logic busy
);
    nmi_state_t state, state_nxt;

    always_comb begin
        state_nxt = state;
        unique case (state)
            NMI_IDLE: if (req) state_nxt = NMI_HIGH;
            NMI_HIGH: state_nxt = NMI_IDLE;
        endcase
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) state <= NMI_IDLE;
        else        state <= state_nxt;
    end

    always_comb begin
        force_en  = 1'b0;
        force_lvl = 1'b0;
        busy      = 1'b0;
        unique case (state)
            NMI_IDLE: begin
                force_en  = req;
                force_lvl = 1'b1;
            end
            NMI_HIGH: begin
                force_en  = 1'b1;
                force_lvl = 1'b0;
                busy      = 1'b1;
            end
        endcase
    end
endmodule

// File: rtl/gpio_byte_ctrl.sv
module gpio_byte_ctrl
    import gpio_pkg::*;
#(
    parameter int unsigned NPIN    = DEF_NPIN,
    parameter int unsigned NLVL    = DEF_NLVL,
    parameter int unsigned NIRQ    = DEF_NIRQ,
    parameter int unsigned AW      = DEF_AW,
    parameter int unsigned LOW_PIN = DEF_LOW_PIN,
    parameter int unsigned NMI_PIN = DEF_NMI_PIN
) (
    input  logic            clk,
    input  logic            rst_n,
    input  logic [AW-1:0]   bus_addr,
    input  logic            bus_wr,
    input  logic            bus_rd,
    input  logic [7:0]      bus_wdata,
    output logic [7:0]      bus_rdata,
    input  logic            ext_set,
    input  logic [AW-1:0]   ext_idx,
    input  logic            ext_level,
    input  logic            nmi_req,
    output logic [NPIN-1:0] pin_level,
    output logic [NIRQ-1:0] irq,
    output logic            err_flag
);
    logic          is_lvl, is_ctrl;
    logic [AW-1:0] pin_idx;
    logic [7:0]    ctrl   [NPIN];
    logic [7:0]    lvl_bank [NLVL];
    logic          force_en, force_lvl, nmi_busy;
    logic [6:0]    wr_bits;
    logic [7:0]    rd_nxt;
    logic          err_hit;

    assign wr_bits = {bus_wdata[7:2], bus_wdata[0]};

    gpio_addr_dec #(.AW(AW), .NLVL(NLVL), .NPIN(NPIN)) u_dec (
        .addr(bus_addr), .is_lvl(is_lvl), .is_ctrl(is_ctrl), .pin_idx(pin_idx)
    );

    gpio_nmi_seq u_nmi (
        .clk(clk), .rst_n(rst_n), .req(nmi_req),
        .force_en(force_en), .force_lvl(force_lvl), .busy(nmi_busy)
    );

    // Level-summary bank: read-only storage, cleared by reset
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            for (int i = 0; i < int'(NLVL); i++) lvl_bank[i] <= 8'h00;
        end else begin
            for (int i = 0; i < int'(NLVL); i++) lvl_bank[i] <= lvl_bank[i];
        end
    end

    for (genvar n = 0; n < int'(NPIN); n++) begin : g_pin
        localparam logic [7:0] RST_VAL = (n == int'(LOW_PIN)) ? 8'h02 : 8'h00;
        logic wr_hit, ext_hit;
        assign wr_hit  = bus_wr && is_ctrl && (pin_idx == AW'(n));
        assign ext_hit = ext_set && (ext_idx == AW'(n));
        gpio_pin_cell #(.RST_VAL(RST_VAL)) u_cell (
            .clk(clk), .rst_n(rst_n),
            .wr_en(wr_hit), .wr_bits(wr_bits),
            .ext_en(ext_hit), .ext_lvl(ext_level),
            .force_en(force_en && (n == int'(NMI_PIN))), .force_lvl(force_lvl),
            .ctrl(ctrl[n])
        );
        assign pin_level[n] = ctrl[n][1];
    end

    for (genvar i = 0; i < int'(NIRQ); i++) begin : g_irq
        if (i == int'(LOW_PIN)) begin : g_low
            assign irq[i] = ~ctrl[i][1];
        end else if (i == int'(NMI_PIN)) begin : g_high
            assign irq[i] = ctrl[i][1];
        end else begin : g_none
            assign irq[i] = 1'b0;
        end
    end

    always_comb begin
        err_hit = 1'b0;
        for (int n = 0; n < int'(NPIN); n++)
            if (ext_set && ext_idx == AW'(n) && ctrl[n][2]) err_hit = 1'b1;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n)       err_flag <= 1'b0;
        else if (err_hit) err_flag <= 1'b1;
    end

    always_comb begin
        rd_nxt = 8'h00;
        for (int i = 0; i < int'(NLVL); i++)
            if (is_lvl && bus_addr == AW'(i)) rd_nxt = lvl_bank[i];
        for (int n = 0; n < int'(NPIN); n++)
            if (is_ctrl && pin_idx == AW'(n)) rd_nxt = ctrl[n];
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n)      bus_rdata <= 8'h00;
        else if (bus_rd) bus_rdata <= rd_nxt;
    end

    AST_LVL_READ_ZERO: assert property (@(posedge clk) disable iff (!rst_n)
        (bus_rd && is_lvl) |=> (bus_rdata == 8'h00)) else $error("lvl read");  // R2

    AST_WR_OE_LEVEL: assert property (@(posedge clk) disable iff (!rst_n)
        (bus_wr && is_ctrl && bus_wdata[2] && !(force_en && pin_idx == AW'(NMI_PIN)))
        |=> (pin_level[$past(pin_idx)] == $past(bus_wdata[0]))) else $error("oe wr");  // R4

    AST_WR_KEEP_LEVEL: assert property (@(posedge clk) disable iff (!rst_n)
        (bus_wr && is_ctrl && !bus_wdata[2] && !(force_en && pin_idx == AW'(NMI_PIN)))
        |=> (pin_level[$past(pin_idx)] == $past(pin_level[pin_idx]))) else $error("keep");  // R4

    AST_NMI_RISE: assert property (@(posedge clk) disable iff (!rst_n)
        (nmi_req && !nmi_busy) |=> irq[NMI_PIN]) else $error("nmi rise");  // R8

    AST_NMI_ONE_CYCLE: assert property (@(posedge clk) disable iff (!rst_n)
        (nmi_req && !nmi_busy) |=> ##1 !irq[NMI_PIN]) else $error("nmi width");  // R8

    AST_ERR_STICKY: assert property (@(posedge clk) disable iff (!rst_n)
        err_flag |=> err_flag) else $error("err sticky");  // R9
endmodule

// File: tb/gpio_byte_ctrl_test.sv
module gpio_byte_ctrl_test;
    localparam int NPIN = 36;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic [5:0]  bus_addr = '0;
    logic        bus_wr = 1'b0, bus_rd = 1'b0;
    logic [7:0]  bus_wdata = '0;
    logic [7:0]  bus_rdata;
    logic        ext_set = 1'b0;
    logic [5:0]  ext_idx = '0;
    logic        ext_level = 1'b0;
    logic        nmi_req = 1'b0;
    logic [35:0] pin_level;
    logic [9:0]  irq;
    logic        err_flag;

    int tests = 0;
    int fails = 0;
    logic [7:0] mdl [NPIN];

    always #2.5 clk = ~clk;

    gpio_byte_ctrl uut (
        .clk(clk), .rst_n(rst_n), .bus_addr(bus_addr), .bus_wr(bus_wr),
        .bus_rd(bus_rd), .bus_wdata(bus_wdata), .bus_rdata(bus_rdata),
        .ext_set(ext_set), .ext_idx(ext_idx), .ext_level(ext_level),
        .nmi_req(nmi_req), .pin_level(pin_level), .irq(irq), .err_flag(err_flag)
    );

    task automatic check(input string req, input logic [63:0] act, input logic [63:0] exp);
        tests++;
        if (act !== exp) begin
            fails++;
            $display("FAIL %s: actual %0h expected %0h", req, act, exp);
        end
    endtask

    function automatic logic [7:0] exp_read(input int a);
        if (a >= 8 && a < 8 + NPIN) return mdl[a-8];
        return 8'h00;
    endfunction

    function automatic logic [35:0] exp_levels();
        logic [35:0] v;
        for (int n = 0; n < NPIN; n++) v[n] = mdl[n][1];
        return v;
    endfunction

    function automatic logic [9:0] exp_irq();
        logic [9:0] v = '0;
        v[1] = ~mdl[1][1];
        v[9] = mdl[9][1];
        return v;
    endfunction

    task automatic bus_write(input int a, input logic [7:0] d);
        @(negedge clk);
        bus_addr = 6'(a); bus_wdata = d; bus_wr = 1'b1;
        @(negedge clk);
        bus_wr = 1'b0;
        if (a >= 8 && a < 8 + NPIN)
            mdl[a-8] = {d[7:2], d[2] ? d[0] : mdl[a-8][1], d[0]};
    endtask

    task automatic bus_read(input int a, output logic [7:0] d);
        @(negedge clk);
        bus_addr = 6'(a); bus_rd = 1'b1;
        @(negedge clk);
        bus_rd = 1'b0;
        d = bus_rdata;
    endtask

    task automatic ext_event(input int p, input logic lv);
        @(negedge clk);
        ext_idx = 6'(p); ext_level = lv; ext_set = 1'b1;
        @(negedge clk);
        ext_set = 1'b0;
        if (p < NPIN) mdl[p][1] = lv;
    endtask

    task automatic check_outputs(input string req);
        check({req, " R11 level"}, 64'(pin_level), 64'(exp_levels()));
        check({req, " R6/R7 irq"}, 64'(irq), 64'(exp_irq()));
    endtask

    task automatic sweep_read(input string req);
        logic [7:0] d;
        for (int a = 0; a < 64; a++) begin
            bus_read(a, d);
            check(req, 64'(d), 64'(exp_read(a)));
        end
    endtask

    initial begin
        repeat (200000) @(posedge clk);
        fails++;
        $display("FAIL watchdog: actual timeout expected finish");
        $display("[TB] %0d tests run, %0d failed", tests, fails);
        $finish;
    end

    initial begin
        logic [7:0] d;
        for (int n = 0; n < NPIN; n++) mdl[n] = 8'h00;
        mdl[1] = 8'h02;
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);

        // R1 reset state
        check("R1 irq", 64'(irq), 64'h0);
        check("R1 err", 64'(err_flag), 64'h0);
        check_outputs("R1");
        sweep_read("R1/R2/R3 reset read");

        // R4 write sweep over every pin
        for (int p = 0; p < NPIN; p++) begin
            for (int k = 0; k < 16; k++) begin
                bus_write(8 + p, 8'(k * 17));
                check_outputs("R4");
                bus_read(8 + p, d);
                check("R3/R4 readback", 64'(d), 64'(mdl[p]));
            end
        end

        // R2/R3 writes outside the control range are ignored
        for (int a = 0; a < 8; a++) bus_write(a, 8'hFF);
        for (int a = 44; a < 64; a++) bus_write(a, 8'hFF);
        check_outputs("R2/R3 ignored writes");
        sweep_read("R2/R3 after ignored writes");

        // R10 read data held without strobe
        bus_read(9, d);
        @(negedge clk);
        bus_addr = 6'd8;
        @(negedge clk);
        check("R10 hold", 64'(bus_rdata), 64'(mdl[1]));

        // Clear every pin with output disabled
        for (int p = 0; p < NPIN; p++) bus_write(8 + p, 8'h00);
        check_outputs("R4 clear");

        // R5 events on undriven pins
        for (int p = 0; p < NPIN; p++) begin
            ext_event(p, 1'b1);
            check_outputs("R5 event high");
            ext_event(p, 1'b0);
            check_outputs("R5 event low");
        end
        check("R9 no err when OE off", 64'(err_flag), 64'h0);
        ext_event(40, 1'b1);
        check_outputs("R5 index out of range");

        // R5 write wins over same-cycle event
        @(negedge clk);
        bus_addr = 6'd13; bus_wdata = 8'h05; bus_wr = 1'b1;
        ext_idx = 6'd5; ext_level = 1'b0; ext_set = 1'b1;
        @(negedge clk);
        bus_wr = 1'b0; ext_set = 1'b0;
        mdl[5] = 8'h07;
        check_outputs("R5 collision");
        check("R9 collision no err", 64'(err_flag), 64'h0);

        // R5/R9 event on driven pin accepted and flagged
        ext_event(5, 1'b0);
        check_outputs("R5 event on driven pin");
        check("R9 err set", 64'(err_flag), 64'h1);
        repeat (5) @(negedge clk);
        check("R9 err sticky", 64'(err_flag), 64'h1);

        // R8 NMI pulse from low level
        check("R8 pre", 64'(irq[9]), 64'h0);
        @(negedge clk); nmi_req = 1'b1;
        @(negedge clk); nmi_req = 1'b0;
        check("R8 pulse high", 64'(irq[9]), 64'h1);
        @(negedge clk);
        check("R8 pulse low", 64'(irq[9]), 64'h0);

        // R8 from high level, request held two cycles
        ext_event(9, 1'b1);
        check("R7 pin9 high", 64'(irq[9]), 64'h1);
        @(negedge clk); nmi_req = 1'b1;
        @(negedge clk);
        check("R8 held high", 64'(irq[9]), 64'h1);
        @(negedge clk); nmi_req = 1'b0;
        check("R8 second req ignored", 64'(irq[9]), 64'h0);
        @(negedge clk);
        check("R8 stays low", 64'(irq[9]), 64'h0);
        mdl[9][1] = 1'b0;
        check_outputs("R8 final");

        // R8 override of a same-cycle write to pin 9
        @(negedge clk);
        nmi_req = 1'b1; bus_addr = 6'd17; bus_wdata = 8'h04; bus_wr = 1'b1;
        @(negedge clk);
        nmi_req = 1'b0; bus_wr = 1'b0;
        mdl[9] = 8'h04;
        check("R8 override write", 64'(irq[9]), 64'h1);
        @(negedge clk);
        check("R8 override end", 64'(irq[9]), 64'h0);
        bus_read(17, d);
        check("R8 readback", 64'(d), 64'h04);

        $display("[TB] %0d tests run, %0d failed", tests, fails);
        $finish;
    end
endmodule